// File: doc/BRIEF.md
# Trap Arbitration and Vector Generator

This block sits beside a processor core's exception logic and settles which trap, if any, is taken in each cycle. Three hardware sources present a 6-bit error code each: the core itself, the program memory controller and the data memory controller. A code of zero means "no request". A software trap request arrives with a 4-bit immediate, the instruction's guard flag and the current instruction width mode. The block picks one winner and produces a one-cycle pulse, one cycle later, carrying the winner's code, its kind and the 32-bit address of its vector slot.

Among hardware requests the largest error code is chosen. Hardware vectors sit at the base of the address space, with four bytes per code. Software vectors start at byte 0x20 and cover 0x20 through 0x5C. A status enable masks hardware traps and leaves software traps alone. A separate select bit decides whether data memory errors become traps. Saving state, updating the status register and redirecting the pipeline are left to the surrounding logic.

Top module: `trap_vector_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is zero after that edge, whatever the request inputs hold.
- R2: A hardware trap with winning code C gives, one clock later, `trap_pulse`=1, `trap_is_hw`=1, `trap_code`=C and `trap_vector`=C*4.
- R3: When more than one hardware source requests in the same cycle, the largest code among the enabled sources is the one reported.
- R4: An error code of 0 from any source is never reported as a trap.
- R5: With `hw_enable`=0, no hardware trap is reported from any source. Software traps are still taken.
- R6: Codes on `dmc_code` count as requests only while `dmem_trap_sel`=1. Core and program-memory requests do not depend on that bit or on the guard.
- R7: A software trap with immediate I gives, one clock later, `trap_pulse`=1, `trap_is_hw`=0, `trap_code`=I (zero-extended) and `trap_vector`=0x20+I*4.
- R8: With `mode32`=1, a software request fires only if `sw_guard`=1. With `mode32`=0, it fires whatever the value of `sw_guard`.
- R9: If a qualifying hardware trap and a qualifying software trap arrive in the same cycle, only the hardware trap is reported and the software request is dropped.
- R10: `trap_pulse` is high for exactly one cycle per qualifying request cycle. In any cycle after one with no qualifying request, `trap_pulse`, `trap_is_hw`, `trap_code` and `trap_vector` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_code | input | 6 | Core error code, 0 = none |
| pmc_code | input | 6 | Program memory controller error code, 0 = none |
| dmc_code | input | 6 | Data memory controller error code, 0 = none |
| sw_req | input | 1 | Software trap instruction present |
| sw_imm | input | 4 | Software trap immediate |
| sw_guard | input | 1 | Guard value of the software trap instruction |
| mode32 | input | 1 | 1 = 32-bit instruction mode, 0 = 16-bit mode |
| hw_enable | input | 1 | Hardware trap enable from the status register |
| dmem_trap_sel | input | 1 | 1 = data memory errors raise traps |
| trap_pulse | output | 1 | One-cycle trap-taken strobe |
| trap_code | output | 6 | Winning error code or zero-extended immediate |
| trap_is_hw | output | 1 | 1 = hardware trap, 0 = software trap |
| trap_vector | output | 32 | Vector slot address |

## Verification
On every cycle the assertions check the fixed link between a reported code and its vector for both kinds of trap. They also check that a winning hardware code is never below any enabled request, that the enable really masks hardware traps, that hardware beats software, and that idle cycles give zero outputs. Some properties can only be shown by the bench's scenarios, which compare every cycle against a behavioural model: the guard rule depending on instruction mode, the effect of the data-memory select, the dropping of zero codes from each single source, and the exact one-cycle latency across mixed random traffic.

// File: rtl/trap_vec_pkg.sv
// Package: shared widths, vector bases and the selection record used by the
// trap arbitration and vector generator. Assumes byte addressing with one
// 32-bit vector slot per code.
package trap_vec_pkg;
    parameter int CODE_W     = 6;
    parameter int IMM_W      = 4;
    parameter int ADDR_W     = 32;
    parameter int NUM_HW_SRC = 3;
    parameter int VEC_SHIFT  = 2;
    parameter logic [ADDR_W-1:0] HW_BASE = 32'h0000_0000;
    parameter logic [ADDR_W-1:0] SW_BASE = 32'h0000_0020;

    localparam int SRC_CORE = 0;
    localparam int SRC_PMC  = 1;
    localparam int SRC_DMC  = 2;

    typedef struct packed {
        logic              valid;
        logic              is_hw;
        logic [CODE_W-1:0] code;
    } trap_sel_t;
endpackage

// File: rtl/hw_trap_arbiter.sv
// Hardware trap arbiter: masks each source with the global enable and its own
// allow bit, then returns the largest non-zero code. Assumes code 0 means
// "no request"; combinational apart from the assertions.
module hw_trap_arbiter #(
    parameter int N = 3,
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_code [N],
    input  logic [N-1:0] src_allow,
    input  logic         hw_en,
    output logic         hit,
    output logic [W-1:0] win_code
);
    logic [W-1:0] gated [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            // Zero out a source that is disabled globally or by its own select.
            assign gated[g] = (hw_en && src_allow[g]) ? src_code[g] : '0;

            // R3: the winner is never below any enabled request
            a_r3_winner_is_max: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_en && src_allow[g]) |-> (win_code >= src_code[g]));
        end
    endgenerate

    // Keep the largest gated code; zero stays zero, so code 0 is never a hit.
    always_comb begin
        win_code = '0;
        for (int i = 0; i < N; i++) begin
            if (gated[i] > win_code) win_code = gated[i];
        end
    end

    assign hit = (win_code != '0);

    // R5: a masked hardware path never wins
    a_r5_mask_blocks_hw: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |-> !hit);
endmodule

// File: rtl/sw_trap_qualifier.sv
// Software trap qualifier: a trap request fires when its guard holds in
// 32-bit mode, and always in 16-bit mode. Assumes the request is valid for
// one cycle per trap instruction.
module sw_trap_qualifier #(
    parameter int IMM_W = 4
) (
    input  logic             sw_req,
    input  logic [IMM_W-1:0] sw_imm,
    input  logic             sw_guard,
    input  logic             mode32,
    output logic             fire,
    output logic [IMM_W-1:0] imm_out
);
    // Apply the guard only in the wide instruction mode.
    always_comb begin
        fire    = sw_req && (!mode32 || sw_guard);
        imm_out = sw_imm;
    end
endmodule

// File: rtl/trap_vector_calc.sv
// Vector address calculator: turns a selection record into the slot address.
// Hardware codes index from HW_BASE and software immediates from SW_BASE,
// one slot per code of (1 << VEC_SHIFT) bytes. Combinational.
module trap_vector_calc
    import trap_vec_pkg::*;
(
    input  trap_sel_t          sel,
    output logic [ADDR_W-1:0]  vector
);
    logic [ADDR_W-1:0] offset;

    // Scale the code to a byte offset and add the base for its kind.
    always_comb begin
        offset = ADDR_W'(sel.code) << VEC_SHIFT;
        if (!sel.valid)     vector = '0;
        else if (sel.is_hw) vector = HW_BASE | offset;
        else                vector = SW_BASE + offset;
    end
endmodule

// File: rtl/trap_vector_unit.sv
// Top of the trap arbitration and vector generator. Combines the hardware
// arbiter and the software qualifier, gives hardware priority, and registers
// a one-cycle trap strobe with code, kind and vector address. Assumes the
// request inputs are sampled once per clock; synchronous active-low reset.
module trap_vector_unit
    import trap_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  core_code,
    input  logic [5:0]  pmc_code,
    input  logic [5:0]  dmc_code,
    input  logic        sw_req,
    input  logic [3:0]  sw_imm,
    input  logic        sw_guard,
    input  logic        mode32,
    input  logic        hw_enable,
    input  logic        dmem_trap_sel,
    output logic        trap_pulse,
    output logic [5:0]  trap_code,
    output logic        trap_is_hw,
    output logic [31:0] trap_vector
);
    logic [CODE_W-1:0]     src_code [NUM_HW_SRC];
    logic [NUM_HW_SRC-1:0] src_allow;
    logic                  hw_hit;
    logic [CODE_W-1:0]     hw_code;
    logic                  sw_fire;
    logic [IMM_W-1:0]      sw_sel_imm;
    trap_sel_t             sel;
    logic [ADDR_W-1:0]     vec_next;

    // Map the sources to arbiter slots; only the data source has a select.
    always_comb begin
        src_code[SRC_CORE]  = core_code;
        src_code[SRC_PMC]   = pmc_code;
        src_code[SRC_DMC]   = dmc_code;
        src_allow           = '1;
        src_allow[SRC_DMC]  = dmem_trap_sel;
    end

    hw_trap_arbiter #(.N(NUM_HW_SRC), .W(CODE_W)) u_hw_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_code (src_code),
        .src_allow(src_allow),
        .hw_en    (hw_enable),
        .hit      (hw_hit),
        .win_code (hw_code)
    );

    sw_trap_qualifier #(.IMM_W(IMM_W)) u_sw_qual (
        .sw_req  (sw_req),
        .sw_imm  (sw_imm),
        .sw_guard(sw_guard),
        .mode32  (mode32),
        .fire    (sw_fire),
        .imm_out (sw_sel_imm)
    );

    // Pick hardware first, then software, else nothing.
    always_comb begin
        sel = '0;
        if (hw_hit) begin
            sel.valid = 1'b1;
            sel.is_hw = 1'b1;
            sel.code  = hw_code;
        end else if (sw_fire) begin
            sel.valid = 1'b1;
            sel.is_hw = 1'b0;
            sel.code  = CODE_W'(sw_sel_imm);
        end
    end

    trap_vector_calc u_vec (
        .sel   (sel),
        .vector(vec_next)
    );

    // Register the selection; idle cycles clear every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse  <= 1'b0;
            trap_code   <= '0;
            trap_is_hw  <= 1'b0;
            trap_vector <= '0;
        end else begin
            trap_pulse  <= sel.valid;
            trap_code   <= sel.code;
            trap_is_hw  <= sel.is_hw;
            trap_vector <= vec_next;
        end
    end

    // R1: reset clears all outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!trap_pulse && !trap_is_hw && trap_code == '0 && trap_vector == '0));

    // R2: hardware vector is code times four from base zero
    a_r2_hw_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && trap_is_hw) |-> (trap_vector == {24'h0, trap_code, 2'b00}));

    // R4: a reported hardware trap never carries code 0
    a_r4_no_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && trap_is_hw) |-> (trap_code != 6'd0));

    // R7: software vector lies in 0x20..0x5C and matches the immediate
    a_r7_sw_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse && !trap_is_hw) |->
            (trap_code < 6'd16 && trap_vector == 32'h20 + {24'h0, trap_code, 2'b00}));

    // R9: hardware wins over a simultaneous software request
    a_r9_hw_over_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_hit && sw_fire) |=> (trap_pulse && trap_is_hw));

    // R10: idle cycle gives all-zero outputs
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> (!trap_is_hw && trap_code == '0 && trap_vector == '0));
endmodule

// File: tb/trap_vector_unit_bench.sv
`timescale 1ns/1ps
// Bench: drives inputs on the falling edge, predicts the next registered
// outputs with a behavioural model, and compares on the next falling edge.
module trap_vector_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  core_code = '0, pmc_code = '0, dmc_code = '0;
    logic        sw_req = 1'b0, sw_guard = 1'b0, mode32 = 1'b0;
    logic [3:0]  sw_imm = '0;
    logic        hw_enable = 1'b0, dmem_trap_sel = 1'b0;
    logic        trap_pulse, trap_is_hw;
    logic [5:0]  trap_code;
    logic [31:0] trap_vector;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    trap_vector_unit u_trap_vector_unit (
        .clk(clk), .rst_n(rst_n),
        .core_code(core_code), .pmc_code(pmc_code), .dmc_code(dmc_code),
        .sw_req(sw_req), .sw_imm(sw_imm), .sw_guard(sw_guard), .mode32(mode32),
        .hw_enable(hw_enable), .dmem_trap_sel(dmem_trap_sel),
        .trap_pulse(trap_pulse), .trap_code(trap_code),
        .trap_is_hw(trap_is_hw), .trap_vector(trap_vector)
    );

    task automatic compare(input string tag, input bit ep, input int ec,
                           input bit eh, input longint ev);
        n_vec++;
        if (trap_pulse !== ep || trap_code !== 6'(ec) || trap_is_hw !== eh ||
            trap_vector !== 32'(ev)) begin
            n_fail++;
            $display("FAIL %s: got pulse=%0b code=%0d hw=%0b vec=%h, expected pulse=%0b code=%0d hw=%0b vec=%h",
                     tag, trap_pulse, trap_code, trap_is_hw, trap_vector, ep, ec, eh, 32'(ev));
        end
    endtask

    // Apply one cycle of stimulus, predict, and check after the edge.
    task automatic step(input int c, input int p, input int d, input bit sr,
                        input int im, input bit gd, input bit m32,
                        input bit he, input bit ds, input string tag);
        int best;
        bit ep, eh;
        int ec;
        longint ev;
        core_code = 6'(c); pmc_code = 6'(p); dmc_code = 6'(d);
        sw_req = sr; sw_imm = 4'(im); sw_guard = gd; mode32 = m32;
        hw_enable = he; dmem_trap_sel = ds;
        best = 0;
        if (he) begin
            if (c > best) best = c;
            if (p > best) best = p;
            if (ds && d > best) best = d;
        end
        ep = 0; eh = 0; ec = 0; ev = 0;
        if (best > 0) begin
            ep = 1; eh = 1; ec = best; ev = best * 4;
        end else if (sr && (!m32 || gd)) begin
            ep = 1; eh = 0; ec = im; ev = 32 + im * 4;
        end
        @(negedge clk);
        compare(tag, ep, ec, eh, ev);
    endtask

    initial begin
        // R1: reset dominates active requests
        core_code = 6'd7; sw_req = 1'b1; hw_enable = 1'b1;
        repeat (3) @(negedge clk);
        compare("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        //     core  pmc  dmc  sr im gd m32 he ds
        step(5,    0,   0,   0, 0, 0, 0,  1, 0, "R2");
        step(0,    6'h1F, 0, 0, 0, 0, 0,  1, 0, "R2");
        step(0,    0,   0,   0, 0, 0, 0,  1, 1, "R10");
        step(7,    6'h1E, 6'h25, 0, 0, 0, 0, 1, 1, "R3");
        step(7,    6'h1A, 6'h3F, 0, 0, 0, 0, 1, 1, "R3");
        step(6,    5,   0,   0, 0, 0, 0,  1, 0, "R3");
        step(0,    0,   0,   0, 0, 0, 0,  1, 1, "R4");
        step(0,    0,   0,   1, 3, 0, 0,  1, 1, "R4");
        step(5,    6'h1F, 6'h20, 0, 0, 0, 0, 0, 1, "R5");
        step(5,    0,   0,   1, 9, 1, 1,  0, 0, "R5");
        step(0,    0,   6'h24, 0, 0, 0, 0, 1, 0, "R6");
        step(0,    0,   6'h24, 0, 0, 0, 0, 1, 1, "R6");
        step(3,    0,   6'h26, 0, 0, 0, 0, 1, 0, "R6");
        step(3,    0,   0,   0, 0, 0, 1,  1, 0, "R6");
        step(0,    0,   0,   1, 0, 0, 0,  1, 0, "R7");
        step(0,    0,   0,   1, 15, 0, 0, 1, 0, "R7");
        step(0,    0,   0,   1, 9, 0, 1,  1, 0, "R8");
        step(0,    0,   0,   1, 9, 1, 1,  1, 0, "R8");
        step(0,    0,   0,   1, 4, 0, 0,  1, 0, "R8");
        step(0,    6'h1D, 0, 1, 2, 1, 1,  1, 0, "R9");
        step(0,    0,   6'h21, 1, 2, 0, 0, 1, 1, "R9");
        step(0,    0,   0,   0, 0, 0, 0,  1, 0, "R10");
        step(0,    0,   6'h21, 1, 6, 0, 0, 1, 0, "R10");
        for (int k = 0; k < 400; k++) begin
            step($urandom_range(0, 7) * ($urandom_range(0, 1)),
                 ($urandom_range(0, 1) ? $urandom_range(24, 31) : 0),
                 ($urandom_range(0, 1) ? $urandom_range(32, 63) : 0),
                 1'($urandom_range(0, 1)), $urandom_range(0, 15),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 "R3 mix");
        end
        rst_n = 1'b0;
        core_code = 6'd6;
        hw_enable = 1'b1;
        @(negedge clk);
        compare("R1", 0, 0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule